// File: doc/BRIEF.md
# Accumulator Adder with Condition-Code Update

This unit performs the addition step of an 8/16-bit accumulator processor and works out the condition-code byte that follows from it. A pulse on the start strobe captures four things: the operation code, the width select, the two operands and the current condition-code byte. One clock later the unit presents the sum and the updated condition codes together, along with a single-cycle done pulse.

Four operations are provided:

- **Plain add.** Works at byte or word width.
- **Add with carry.** Works at byte or word width and folds in the incoming carry flag, so wider sums can be built from a chain of steps.
- **Unsigned index add.** Adds a zero-extended byte to a 16-bit index and leaves every flag untouched.
- **Signed index add.** Sign-extends the byte and touches only the zero flag.

The width select plays the role of the destination size in register-to-register adds. The source-size input tells the unit whether the second operand is naturally a byte or a word, so that a byte source can be widened when the destination is 16 bits.

Top module: `acc_adder_cc`

## Requirements
- R1: With op=0 (add) and wide_i=0, res_o[7:0] is a_i[7:0]+b_i[7:0] mod 256. The flag bits are: H (bit 5) set on a carry from bit 3 into bit 4, N (bit 3) equal to result bit 7, Z (bit 2) set when the result byte is zero, and C (bit 0) equal to the carry out of bit 7.
- R2: With op=1 (add with carry), the incoming cc_i[0] is added to the two operands at either width. The flags follow the same rules as plain add at that width.
- R3: With wide_i=1 and op 0 or 1, the result is 16 bits, N equals result bit 15, C is the carry out of bit 15, and H (bit 5) keeps its incoming value.
- R4: V (bit 1) is set when both addends have equal sign bits and the result's sign bit differs from them. The sign bit is the top bit of the active width.
- R5: With op=2 (unsigned index add), res_o = a_i + {8'h00, b_i[7:0]} mod 65536 and cc_o equals cc_i. For example, 0x301B with byte 0xFF gives 0x311A.
- R6: With op=3 (signed index add), res_o = a_i plus the sign-extended b_i[7:0], mod 65536. Only Z (bit 2) changes, and it is set when the 16-bit result is zero. For example, 0x301B with byte 0xFF gives 0x301A.
- R7: For op 0 or 1 with wide_i=1 and src_wide_i=0, the second addend is {8'h00, b_i[7:0]}. With wide_i=0, only b_i[7:0] is used, whatever src_wide_i is.
- R8: For byte-width add and add with carry, res_o[15:8] is zero.
- R9: E (bit 7), F (bit 6) and I (bit 4) of cc_o always equal the captured cc_i bits.
- R10: res_o, cc_o and done_o are registered. done_o is high exactly in the cycle after a cycle with start_i high. Without start_i, res_o and cc_o hold their values.
- R11: While rst_n is low, res_o, cc_o and done_o are all zero.
- R12: A 32-bit sum is formed correctly by two steps: a word add of the low halves, then a word add with carry of the high halves using the cc_o of the first step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Capture and compute strobe |
| op_i | input | 2 | 0 add, 1 add with carry, 2 unsigned index add, 3 signed index add |
| wide_i | input | 1 | Destination width: 0 byte, 1 word |
| src_wide_i | input | 1 | Source width: 0 byte, 1 word |
| a_i | input | 16 | Destination/first operand |
| b_i | input | 16 | Source/second operand |
| cc_i | input | 8 | Current condition codes (E,F,H,I,N,Z,V,C from bit 7 to bit 0) |
| res_o | output | 16 | Registered result |
| cc_o | output | 8 | Registered new condition codes |
| done_o | output | 1 | One-cycle pulse marking valid outputs |

## Verification
The bench builds the unit with its default byte width of 8, so the word lane is 16 bits. At that size, exhaustive-looking random coverage of the carry, half-carry and sign boundaries is reached quickly with a few thousand operations. The default width also puts the documented index examples (0x301B with 0xFF) and a two-step 32-bit carry chain directly within reach as directed cases.

// File: rtl/acc_add_pkg.sv
`timescale 1ns/1ps
package acc_add_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADC  = 2'd1,
        OP_IDXU = 2'd2,
        OP_IDXS = 2'd3
    } add_op_e;

    // condition-code bit positions
    localparam int CC_E = 7;
    localparam int CC_F = 6;
    localparam int CC_H = 5;
    localparam int CC_I = 4;
    localparam int CC_N = 3;
    localparam int CC_Z = 2;
    localparam int CC_V = 1;
    localparam int CC_C = 0;
endpackage

// File: rtl/acc_add_operand.sv
`timescale 1ns/1ps
module acc_add_operand #(
    parameter int BW = 8,
    localparam int WW = 2 * BW
) (
    input  acc_add_pkg::add_op_e op,
    input  logic                 src_wide,
    input  logic [WW-1:0]        b,
    input  logic                 cc_carry,
    output logic [WW-1:0]        addend_w,
    output logic [BW-1:0]        addend_b,
    output logic                 cin
);
    import acc_add_pkg::*;

    always_comb begin
        addend_b = b[BW-1:0];
        cin      = (op == OP_ADC) ? cc_carry : 1'b0;
        unique case (op)
            OP_IDXU: addend_w = {{BW{1'b0}}, b[BW-1:0]};
            OP_IDXS: addend_w = {{BW{b[BW-1]}}, b[BW-1:0]};
            default: addend_w = src_wide ? b : {{BW{1'b0}}, b[BW-1:0]};
        endcase
    end
endmodule

// File: rtl/acc_add_lane.sv
`timescale 1ns/1ps
module acc_add_lane #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcarry,
    output logic         ovf
);
    logic [W:0] full;
    logic [4:0] nib;

    always_comb begin
        full   = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        nib    = {1'b0, a[3:0]} + {1'b0, b[3:0]} + {4'b0, cin};
        sum    = full[W-1:0];
        cout   = full[W];
        hcarry = nib[4];
        ovf    = (a[W-1] == b[W-1]) && (full[W-1] != a[W-1]);
    end
endmodule

// File: rtl/acc_add_flags.sv
`timescale 1ns/1ps
module acc_add_flags #(
    parameter int BW = 8,
    localparam int WW = 2 * BW
) (
    input  acc_add_pkg::add_op_e op,
    input  logic                 wide,
    input  logic [7:0]           cc_in,
    input  logic [BW-1:0]        b_sum,
    input  logic                 b_cout,
    input  logic                 b_hc,
    input  logic                 b_ovf,
    input  logic [WW-1:0]        w_sum,
    input  logic                 w_cout,
    input  logic                 w_ovf,
    output logic [WW-1:0]        res,
    output logic [7:0]           cc_out
);
    import acc_add_pkg::*;

    always_comb begin
        cc_out = cc_in;
        res    = w_sum;
        unique case (op)
            OP_IDXU: begin
                res = w_sum;
            end
            OP_IDXS: begin
                cc_out[CC_Z] = (w_sum == '0);
            end
            default: begin
                if (wide) begin
                    cc_out[CC_N] = w_sum[WW-1];
                    cc_out[CC_Z] = (w_sum == '0);
                    cc_out[CC_V] = w_ovf;
                    cc_out[CC_C] = w_cout;
                end else begin
                    res          = {{BW{1'b0}}, b_sum};
                    cc_out[CC_H] = b_hc;
                    cc_out[CC_N] = b_sum[BW-1];
                    cc_out[CC_Z] = (b_sum == '0);
                    cc_out[CC_V] = b_ovf;
                    cc_out[CC_C] = b_cout;
                end
            end
        endcase
    end
endmodule

// File: rtl/acc_adder_cc.sv
`timescale 1ns/1ps
module acc_adder_cc #(
    parameter int BYTE_W = acc_add_pkg::BYTE_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        op_i,
    input  logic              wide_i,
    input  logic              src_wide_i,
    input  logic [WORD_W-1:0] a_i,
    input  logic [WORD_W-1:0] b_i,
    input  logic [7:0]        cc_i,
    output logic [WORD_W-1:0] res_o,
    output logic [7:0]        cc_o,
    output logic              done_o
);
    import acc_add_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] res;
        logic [7:0]        cc;
        logic              done;
    } state_t;

    state_t state_d, state_q;

    add_op_e           op;
    logic [WORD_W-1:0] addend_w;
    logic [BYTE_W-1:0] addend_b;
    logic              cin;

    assign op = add_op_e'(op_i);

    acc_add_operand #(.BW(BYTE_W)) u_operand (
        .op       (op),
        .src_wide (src_wide_i),
        .b        (b_i),
        .cc_carry (cc_i[CC_C]),
        .addend_w (addend_w),
        .addend_b (addend_b),
        .cin      (cin)
    );

    logic [BYTE_W-1:0] b_sum;
    logic              b_cout, b_hc, b_ovf;
    logic [WORD_W-1:0] w_sum;
    logic              w_cout, w_ovf, w_hc_unused;

    acc_add_lane #(.W(BYTE_W)) u_byte_lane (
        .a      (a_i[BYTE_W-1:0]),
        .b      (addend_b),
        .cin    (cin),
        .sum    (b_sum),
        .cout   (b_cout),
        .hcarry (b_hc),
        .ovf    (b_ovf)
    );

    acc_add_lane #(.W(WORD_W)) u_word_lane (
        .a      (a_i),
        .b      (addend_w),
        .cin    (cin),
        .sum    (w_sum),
        .cout   (w_cout),
        .hcarry (w_hc_unused),
        .ovf    (w_ovf)
    );

    logic [WORD_W-1:0] res_c;
    logic [7:0]        cc_c;

    acc_add_flags #(.BW(BYTE_W)) u_flags (
        .op     (op),
        .wide   (wide_i),
        .cc_in  (cc_i),
        .b_sum  (b_sum),
        .b_cout (b_cout),
        .b_hc   (b_hc),
        .b_ovf  (b_ovf),
        .w_sum  (w_sum),
        .w_cout (w_cout),
        .w_ovf  (w_ovf),
        .res    (res_c),
        .cc_out (cc_c)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = start_i;
        if (start_i) begin
            state_d.res = res_c;
            state_d.cc  = cc_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign res_o  = state_q.res;
    assign cc_o   = state_q.cc;
    assign done_o = state_q.done;
endmodule

// File: rtl/acc_adder_cc_chk.sv
`timescale 1ns/1ps
module acc_adder_cc_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [1:0]  op_i,
    input logic        wide_i,
    input logic [7:0]  cc_i,
    input logic [15:0] res_o,
    input logic [7:0]  cc_o,
    input logic        done_o
);
    // R10
    done_follows_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> done_o);
    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> !done_o);
    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> ($stable(res_o) && $stable(cc_o)));
    // R9
    passthru_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (cc_o[7:6] == $past(cc_i[7:6]) && cc_o[4] == $past(cc_i[4])));
    // R5
    idxu_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 2'd2) |=> (cc_o == $past(cc_i)));
    // R6
    idxs_zero_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && op_i == 2'd3) |=>
        ({cc_o[7:3], cc_o[1:0]} == {$past(cc_i[7:3]), $past(cc_i[1:0])}
         && cc_o[2] == (res_o == 16'h0)));
    // R8
    byte_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_i[1] && !wide_i) |=> (res_o[15:8] == 8'h00 && cc_o[3] == res_o[7]));
    // R3
    word_h_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !op_i[1] && wide_i) |=> (cc_o[5] == $past(cc_i[5]) && cc_o[3] == res_o[15]));
endmodule

bind acc_adder_cc acc_adder_cc_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .op_i    (op_i),
    .wide_i  (wide_i),
    .cc_i    (cc_i),
    .res_o   (res_o),
    .cc_o    (cc_o),
    .done_o  (done_o)
);

// File: tb/sim_acc_adder_cc.sv
`timescale 1ns/1ps
module sim_acc_adder_cc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [1:0]  op_i = '0;
    logic        wide_i = 1'b0;
    logic        src_wide_i = 1'b0;
    logic [15:0] a_i = '0;
    logic [15:0] b_i = '0;
    logic [7:0]  cc_i = '0;
    logic [15:0] res_o;
    logic [7:0]  cc_o;
    logic        done_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    acc_adder_cc u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
        .wide_i(wide_i), .src_wide_i(src_wide_i), .a_i(a_i), .b_i(b_i),
        .cc_i(cc_i), .res_o(res_o), .cc_o(cc_o), .done_o(done_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // reference model: returns {res, cc}
    function automatic logic [23:0] model(input logic [1:0] op, input logic wide,
                                          input logic srcw, input logic [15:0] a,
                                          input logic [15:0] b, input logic [7:0] cc);
        logic [15:0] r;
        logic [7:0]  nc;
        int unsigned cin;
        int unsigned bb;
        int unsigned s;
        int unsigned hs;
        cin = (op == 2'd1) ? int'(cc[0]) : 0;
        nc  = cc;
        if (op == 2'd2) begin
            r = a + {8'h00, b[7:0]};
        end else if (op == 2'd3) begin
            r = a + {{8{b[7]}}, b[7:0]};
            nc[2] = (r == 16'h0);
        end else if (wide) begin
            bb = srcw ? int'(b) : int'(b[7:0]);
            s  = int'(a) + bb + cin;
            r  = s[15:0];
            nc[3] = r[15];
            nc[2] = (r == 16'h0);
            nc[1] = (a[15] == bb[15]) && (r[15] != a[15]);
            nc[0] = s[16];
        end else begin
            bb = int'(b[7:0]);
            s  = int'(a[7:0]) + bb + cin;
            hs = int'(a[3:0]) + int'(b[3:0]) + cin;
            r  = {8'h00, s[7:0]};
            nc[5] = hs > 15;
            nc[3] = r[7];
            nc[2] = (r[7:0] == 8'h0);
            nc[1] = (a[7] == bb[7]) && (r[7] != a[7]);
            nc[0] = s[8];
        end
        return {r, nc};
    endfunction

    task automatic run_op(input string tag, input logic [1:0] op, input logic wide,
                          input logic srcw, input logic [15:0] a, input logic [15:0] b,
                          input logic [7:0] cc);
        logic [23:0] exp;
        exp = model(op, wide, srcw, a, b, cc);
        @(negedge clk);
        op_i = op; wide_i = wide; src_wide_i = srcw; a_i = a; b_i = b; cc_i = cc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check({tag, " res"}, {16'h0, res_o}, {16'h0, exp[23:8]});
        check({tag, " cc"}, {24'h0, cc_o}, {24'h0, exp[7:0]});
        check("R10 done high", {31'h0, done_o}, 32'h1);
        a_i = ~a; b_i = ~b; cc_i = ~cc;
        @(negedge clk);
        check("R10 done low", {31'h0, done_o}, 32'h0);
        check("R10 hold", {8'h0, res_o, cc_o}, {8'h0, exp});
    endtask

    initial begin
        logic [15:0] lo_res;
        logic [7:0]  lo_cc;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check("R11 reset", {15'h0, res_o, cc_o, done_o}, 32'h0);
        rst_n = 1'b1;

        run_op("R5 idxu example", 2'd2, 1'b0, 1'b0, 16'h301B, 16'h00FF, 8'hFF);
        check("R5 value", {16'h0, res_o}, 32'h311A);
        run_op("R6 idxs example", 2'd3, 1'b1, 1'b1, 16'h301B, 16'h00FF, 8'h04);
        check("R6 value", {16'h0, res_o}, 32'h301A);
        run_op("R6 idxs zero", 2'd3, 1'b0, 1'b0, 16'h0001, 16'h12FF, 8'hD0);
        run_op("R1 R4 byte ovf", 2'd0, 1'b0, 1'b0, 16'hAA7F, 16'h5501, 8'h00);
        run_op("R1 byte zero carry", 2'd0, 1'b0, 1'b1, 16'h00FF, 16'hFF01, 8'hC0);
        run_op("R2 byte adc", 2'd1, 1'b0, 1'b0, 16'h000F, 16'h0000, 8'h01);
        run_op("R3 R4 word ovf", 2'd0, 1'b1, 1'b1, 16'h8000, 16'h8000, 8'h20);
        run_op("R7 src widen", 2'd0, 1'b1, 1'b0, 16'h1000, 16'hAB12, 8'h00);
        check("R7 value", {16'h0, res_o}, 32'h1012);
        run_op("R8 R9 byte flags", 2'd1, 1'b0, 1'b1, 16'hFF80, 16'hFF80, 8'hD1);

        // R12: 0x1234FFF0 + 0x00010020 = 0x12360010
        run_op("R12 low", 2'd0, 1'b1, 1'b1, 16'hFFF0, 16'h0020, 8'h00);
        lo_res = res_o; lo_cc = cc_o;
        run_op("R12 high", 2'd1, 1'b1, 1'b1, 16'h1234, 16'h0001, lo_cc);
        check("R12 chained sum", {res_o, lo_res}, 32'h12360010);

        for (int i = 0; i < 1500; i++) begin
            run_op("R1 R2 R3 R4 R5 R6 R7 R8 R9 random", 2'($urandom), 1'($urandom),
                   1'($urandom), 16'($urandom), 16'($urandom), 8'($urandom));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule